// File: doc/BRIEF.md
# IDE PIO Register Access Sequencer

This block performs one 16-bit programmed-I/O cycle at a time against the task-file registers of a CompactFlash card in true-IDE mode. The caller pulses a request with a five-bit register select, a direction flag and, for writes, a data word. The sequencer then drives the select onto the card's address and chip-enable pins. It holds that select for a setup window, pulses the active-low read or write strobe for a pulse window, and parks the select for a recovery window. At the end it reports completion with a single-cycle done pulse.

Each window is counted in clock cycles by a parameter. With a 50 MHz clock, the defaults give 80 ns of setup, 180 ns of pulse and 40 ns of recovery. For writes, the block owns the tri-state enable of the data bus. The enable rises together with the select and falls only after the select has been parked for the whole recovery window. For reads, the bus word is captured on the clock edge that ends the strobe, so it is sampled while the strobe is still low.

Top module: `ide_pio_seq`

## Requirements
- R1: While reset is held and after it is released, sel_o is 0x18 (both chip enables high), rd_n_o and wr_n_o are 1, dd_oe_o is 0 and done_o is 0.
- R2: sel_o carries the select bits in the order {nCE1, nCE0, A2, A1, A0}, exactly as given on sel_i when the request is accepted. From the edge that accepts a request, it holds that value with both strobes high for SETUP_CYC cycles (default 4).
- R3: After setup, exactly one strobe is low for PULSE_CYC cycles (default 9): rd_n_o when we_i was 0, wr_n_o when we_i was 1. Both strobes are never low together, and sel_o stays at the accepted select while a strobe is low.
- R4: A read returns on rdata_o the value dd_i had in the last strobe-low cycle. rdata_o keeps that value until the next read completes.
- R5: On the edge that releases the strobe, sel_o returns to 0x18. It stays there for RECOV_CYC cycles (default 2), after which done_o is high for exactly one cycle.
- R6: For a write, dd_oe_o rises on the accepting edge and dd_o shows the accepted write data. dd_oe_o stays high through the recovery window and falls together with the done pulse, at least RECOV_CYC cycles after sel_o returned to 0x18.
- R7: During a read, dd_oe_o stays 0.
- R8: A request is accepted only when no access is in progress. A request raised during an access, and changes to sel_i, we_i or wdata_i after acceptance, have no effect on that access and start no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (50 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled when idle |
| we_i | input | 1 | 1 = register write, 0 = register read |
| sel_i | input | 5 | Register select {nCE1, nCE0, A2, A1, A0} |
| wdata_i | input | 16 | Write data |
| dd_i | input | 16 | Data bus from card |
| dd_o | output | 16 | Data bus to card |
| dd_oe_o | output | 1 | Data bus output enable |
| sel_o | output | 5 | Chip enables and address to card |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the properties that hold for any access. Both strobes are never low together, a select is driven whenever a strobe is low, and the select is parked on the release edge. They also check that the bus enable is never on during a read strobe, that the enable falls only after a parked select with the write strobe high, and that done lasts a single cycle. The exact lengths of the three windows, the cycle in which read data is sampled, and the fact that mid-access requests and input changes are ignored can only be shown by the bench. It counts the phase cycles at the pins, and it drives a different bus value in every strobe cycle except the last.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // Select value that parks both chip enables high.
  localparam logic [4:0] SEL_PARK = 5'h18;

  // Width of a down-counter that must hold values up to max(a,b,c)-1.
  function automatic int cnt_bits(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (m <= 2) return 1;
    return $clog2(m);
  endfunction

endpackage

// File: rtl/ide_phase_timer.sv
module ide_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)          cnt_d = load_val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R2: a loaded count never grows while running
  a_r2_count_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ide_seq_ctrl.sv
module ide_seq_ctrl
  import ide_pio_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int PULSE_CYC = 9,
  parameter int RECOV_CYC = 2,
  parameter int W         = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         expired_i,
  output phase_e       phase_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         accept_o,
  output logic         capture_o,
  output logic         done_o
);

  localparam logic [W-1:0] SU_LD = W'(SETUP_CYC - 1);
  localparam logic [W-1:0] PW_LD = W'(PULSE_CYC - 1);
  localparam logic [W-1:0] RC_LD = W'(RECOV_CYC - 1);

  phase_e phase_q, phase_d;
  logic   done_q, done_d;

  always_comb begin
    phase_d    = phase_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    done_d     = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (req_i) begin
        phase_d    = PH_SETUP;
        load_o     = 1'b1;
        load_val_o = SU_LD;
        accept_o   = 1'b1;
      end
      PH_SETUP: if (expired_i) begin
        phase_d    = PH_STROBE;
        load_o     = 1'b1;
        load_val_o = PW_LD;
      end
      PH_STROBE: if (expired_i) begin
        phase_d    = PH_RECOV;
        load_o     = 1'b1;
        load_val_o = RC_LD;
        capture_o  = 1'b1;
      end
      PH_RECOV: if (expired_i) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  // R8: acceptance only happens from idle
  a_r8_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (phase_q == PH_SETUP));

  // R5: completion is reported only when returning from recovery
  a_r5_done_after_recov: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(phase_q) == PH_RECOV && phase_q == PH_IDLE));

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int PULSE_CYC = 9,
  parameter int RECOV_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  sel_i,
  input  logic [15:0] wdata_i,
  input  logic [15:0] dd_i,
  output logic [15:0] dd_o,
  output logic        dd_oe_o,
  output logic [4:0]  sel_o,
  output logic        rd_n_o,
  output logic        wr_n_o,
  output logic [15:0] rdata_o,
  output logic        done_o
);

  localparam int CW = cnt_bits(SETUP_CYC, PULSE_CYC, RECOV_CYC);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  phase_e          phase;
  logic            load, accept, capture, expired, tmr_en;
  logic [CW-1:0]   load_val;

  assign tmr_en = (phase != PH_IDLE) | req_i;

  ide_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .RECOV_CYC(RECOV_CYC), .W(CW)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n), .req_i(req_i), .expired_i(expired),
    .phase_o(phase), .load_o(load), .load_val_o(load_val),
    .accept_o(accept), .capture_o(capture), .done_o(done_o)
  );

  ide_phase_timer #(.W(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(tmr_en), .load_i(load),
    .load_val_i(load_val), .expired_o(expired)
  );

  // Request capture
  logic        we_q;
  logic [4:0]  sel_q;
  logic [15:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      sel_q   <= SEL_PARK;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= we_i;
      sel_q   <= sel_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)                 rdata_q <= '0;
    else if (capture && !we_q)  rdata_q <= dd_i;
  end

  logic sel_live, strobe_on;
  assign sel_live  = (phase == PH_SETUP) || (phase == PH_STROBE);
  assign strobe_on = (phase == PH_STROBE);

  assign sel_o   = sel_live ? sel_q : SEL_PARK;
  assign rd_n_o  = !(strobe_on && !we_q);
  assign wr_n_o  = !(strobe_on && we_q);
  assign dd_oe_o = we_q && (phase != PH_IDLE);
  assign dd_o    = wdata_q;
  assign rdata_o = rdata_q;

  // R3: never both strobes
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R3: a select is driven while a strobe is low
  a_r3_sel_during_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> (sel_o != SEL_PARK));

  // R5: strobe release parks the select
  a_r5_park_on_release: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(rd_n_o) || $rose(wr_n_o)) |-> (sel_o == SEL_PARK));

  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: no bus drive during a read strobe
  a_r7_no_oe_read: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_n_o |-> !dd_oe_o);

  // R6: enable drops only after a parked select with strobe high
  a_r6_oe_after_park: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(dd_oe_o) |-> ($past(sel_o) == SEL_PARK && $past(wr_n_o) && done_o));

endmodule

// File: tb/ide_pio_seq_tb.sv
module ide_pio_seq_tb;

  localparam int CLK_PERIOD = 20;
  localparam int TSU  = 4;
  localparam int TPW  = 9;
  localparam int TREC = 2;
  localparam logic [4:0] PARK = 5'h18;

  logic        clk, rst_n, req, we;
  logic [4:0]  sel;
  logic [15:0] wdata, dd_in;
  logic [15:0] dd_out, rdata;
  logic        dd_oe, rd_n, wr_n, done;
  logic [4:0]  sel_out;

  typedef struct {
    logic        we;
    logic [4:0]  sel;
    logic [15:0] wdata;
    logic [15:0] rval;
  } item_t;

  item_t exp_q[$];
  int errors = 0;
  int checks = 0;
  int txn_seen = 0;

  ide_pio_seq #(.SETUP_CYC(TSU), .PULSE_CYC(TPW), .RECOV_CYC(TREC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .sel_i(sel),
    .wdata_i(wdata), .dd_i(dd_in), .dd_o(dd_out), .dd_oe_o(dd_oe),
    .sel_o(sel_out), .rd_n_o(rd_n), .wr_n_o(wr_n), .rdata_o(rdata),
    .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req_tag, what, act, expv);
    end
  endtask

  task automatic issue(input logic w, input logic [4:0] s, input logic [15:0] d,
                       input logic [15:0] rv, input bit poke);
    item_t it;
    it.we = w; it.sel = s; it.wdata = d; it.rval = rv;
    exp_q.push_back(it);
    @(negedge clk);
    req = 1'b1; we = w; sel = s; wdata = d;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      // R8: mid-access request and input changes must be ignored
      repeat (3) @(negedge clk);
      req = 1'b1; we = ~w; sel = 5'h0E; wdata = ~d;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
    sel = 5'h1F; wdata = 16'h0; we = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    item_t e;
    int su, pw, rc;
    dd_in = 16'hFFFF;
    forever begin
      @(negedge clk);
      if (rst_n && sel_out != PARK) begin
        txn_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected access", sel_out, PARK);
          continue;
        end
        e = exp_q.pop_front();
        su = 0; pw = 0; rc = 0;
        while (sel_out != PARK && rd_n && wr_n) begin
          su++;
          if (sel_out != e.sel) check(1'b0, "R2", "setup select", sel_out, e.sel);
          if (dd_oe != e.we) check(1'b0, "R6", "oe in setup", dd_oe, e.we);
          @(negedge clk);
        end
        check(su == TSU, "R2", "setup cycles", su, TSU);
        while (!rd_n || !wr_n) begin
          pw++;
          dd_in = (pw == TPW) ? e.rval : ~e.rval;
          if (e.we) check(!wr_n && rd_n, "R3", "write strobe", {rd_n, wr_n}, 2'b10);
          else      check(!rd_n && wr_n, "R3", "read strobe", {rd_n, wr_n}, 2'b01);
          if (sel_out != e.sel) check(1'b0, "R3", "strobe select", sel_out, e.sel);
          if (e.we && dd_out != e.wdata) check(1'b0, "R6", "write data", dd_out, e.wdata);
          if (!e.we && dd_oe) check(1'b0, "R7", "oe during read", dd_oe, 0);
          @(negedge clk);
        end
        dd_in = 16'hFFFF;
        check(pw == TPW, "R3", "pulse cycles", pw, TPW);
        while (!done) begin
          rc++;
          if (sel_out != PARK) check(1'b0, "R5", "recovery select", sel_out, PARK);
          if (dd_oe != e.we) check(1'b0, "R6", "oe in recovery", dd_oe, e.we);
          @(negedge clk);
        end
        check(rc == TREC, "R5", "recovery cycles", rc, TREC);
        check(dd_oe == 1'b0, "R6", "oe off at done", dd_oe, 0);
        if (!e.we) check(rdata == e.rval, "R4", "read data", rdata, e.rval);
        @(negedge clk);
        check(done == 1'b0, "R5", "done width", done, 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] last_rd;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; sel = 5'h1F; wdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(sel_out == PARK && rd_n && wr_n && !dd_oe && !done, "R1", "reset outputs",
          {sel_out, rd_n, wr_n, dd_oe, done}, {PARK, 4'b1100});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sel_out == PARK && rd_n && wr_n && !dd_oe && !done, "R1", "after reset",
          {sel_out, rd_n, wr_n, dd_oe, done}, {PARK, 4'b1100});

    issue(1'b1, 5'h16, 16'h00E5, 16'h0, 1'b0);   // R2 R6 write device/head
    issue(1'b0, 5'h17, 16'h0,    16'h0058, 1'b0); // R4 read status
    issue(1'b0, 5'h10, 16'h0,    16'hA55A, 1'b0); // R4 read data
    last_rd = 16'hA55A;
    issue(1'b1, 5'h0E, 16'h0004, 16'h0, 1'b0);   // R9-style select order, control
    check(rdata == last_rd, "R4", "rdata held across write", rdata, last_rd);
    issue(1'b1, 5'h13, 16'h1234, 16'h0, 1'b1);   // R8 write with mid-access poke
    issue(1'b0, 5'h12, 16'h0,    16'h0F0F, 1'b1); // R8 read with mid-access poke
    issue(1'b0, 5'h10, 16'h0,    16'hFFFE, 1'b0); // R4 near-all-ones
    // back-to-back: request immediately after done
    issue(1'b1, 5'h10, 16'hBEEF, 16'h0, 1'b0);

    repeat (30) @(negedge clk);
    // R8: no extra access started, all expected items consumed
    check(exp_q.size() == 0, "R8", "pending items", exp_q.size(), 0);
    check(txn_seen == 8, "R8", "access count", txn_seen, 8);
    check(sel_out == PARK && rd_n && wr_n && !dd_oe, "R8", "idle after poke",
          {sel_out, rd_n, wr_n, dd_oe}, {PARK, 3'b110});
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule